// File: doc/BRIEF.md
# On-Demand Pin Input Sampler

This block brings 32 asynchronous pad inputs into the port clock domain through two-flop synchronizers and returns their values on a read port. The synchronizers are split into four banks of eight pins. Each bank has its own sampling-mode bit. When the bit is 1, the bank's flops advance every cycle. When the bit is 0, the bank is idle except while a read is in progress, which saves switching power. Clock gating is modelled as a synchronous flop enable.

A requester raises `rd_req_i` and holds it until `rd_ready_o` is high. If every bank is in continuous mode, the read finishes in the cycle of the request. If any bank is in on-demand mode, the read stalls while those banks' synchronizers advance twice, and only then does it return fresh data. A per-pin input enable forces the returned bit to 0 and also freezes that pin's synchronizer flops.

Top module: `insamp_top`

## Requirements
- R1: Reset clears every synchronizer flop. While no read is requested `rd_ready_o` is 0. A read issued before the first clock edge after reset returns 0 on every pin.
- R2: When all four sampling bits are 0, `rd_ready_o` is low for the first two cycles of a request and high in the third.
- R3: Bank k covers pins 8k to 8k+7 and is controlled by sampling bit k. When all four sampling bits are 1 at the start of a read, `rd_ready_o` is high in the same cycle as the request.
- R4: If at least one sampling bit is 0 at the start of a read, the read stalls for exactly two cycles, even when the other banks run continuously.
- R5: In the cycle where `rd_ready_o` is high, `rd_data_o` equals the pads masked by `in_en_i`, provided the pads are stable from two cycles before the request until ready.
- R6: A pin whose `in_en_i` bit is 0 reads as 0.
- R7: A pin whose `in_en_i` bit is 0 keeps its synchronizer contents. Enabling it again and reading at once returns the value captured before it was disabled.
- R8: A bank in on-demand mode does not advance outside a read. After the pads change while no read is active, a read that switches that bank to continuous mode in the same cycle returns the older value.
- R9: The sampling bits are captured when a read starts. Setting all of them to 1 during a stall does not shorten that stall.
- R10: The requester holds `rd_req_i` until ready. A read completes on the cycle where both signals are high, and `rd_ready_o` is never high without a request. If the request is still held after completion, the next read begins in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pad_i | input | 32 | Asynchronous pad levels |
| in_en_i | input | 32 | Per-pin input enable |
| smp_always_i | input | 4 | Per-bank continuous-sampling bit (bank k = pins 8k..8k+7) |
| rd_req_i | input | 1 | Read request, held until ready |
| rd_ready_o | output | 1 | Read data valid and read complete |
| rd_data_o | output | 32 | Synchronized, enable-masked pin values |

## Verification
Ready is combinational from the request in continuous mode, so it is checked one time unit after the request is driven, before any clock edge. In on-demand mode ready is due at the second rising edge after the request is first seen. The bench drives inputs at falling edges and counts the falling edges until ready appears, so each stall length is measured rather than assumed. For a continuous bank, data is due two edges after a pad change, so the pads settle for at least three cycles before each read, except in the tests that read stale values on purpose.

// File: rtl/insamp_pkg.sv
package insamp_pkg;
  localparam int unsigned DEF_BANKS  = 4;
  localparam int unsigned DEF_BANK_W = 8;
  localparam int unsigned DEF_STALL  = 2;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_STALL = 2'd1,
    RD_DATA  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/insamp_bank.sv
module insamp_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] pin_en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  logic [W-1:0] adv;

  function automatic logic [W-1:0] merge(input logic [W-1:0] old_v,
                                         input logic [W-1:0] new_v,
                                         input logic [W-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  assign adv = {W{run_i}} & pin_en_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= merge(s1_q, d_i, adv);
      s2_q <= merge(s2_q, s1_q, adv);
    end
  end

  assign q_o = s2_q;

  // R7: a bank with no advancing pin keeps both stages
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv == '0) |=> ($stable(s1_q) && $stable(s2_q)));

  // R5: a fully enabled running bank captures the pads
  p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && (&pin_en_i)) |=> (s1_q == $past(d_i)));
endmodule

// File: rtl/insamp_rdctl.sv
module insamp_rdctl
  import insamp_pkg::*;
#(
  parameter int unsigned NB        = 4,
  parameter int unsigned STALL_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] smp_i,
  input  logic          rd_req_i,
  output logic          rd_ready_o,
  output logic [NB-1:0] dem_o
);
  localparam int unsigned CW = $clog2(STALL_CYC + 1);

  rd_state_e     st_q, st_d;
  logic [NB-1:0] snap_q;
  logic [CW-1:0] cnt_q;
  logic          all_run, start_stall, imm_ready;

  assign all_run     = &smp_i;
  assign start_stall = (st_q == RD_IDLE) && rd_req_i && !all_run;
  assign imm_ready   = (st_q == RD_IDLE) && rd_req_i && all_run;

  always_comb begin
    st_d       = st_q;
    dem_o      = '0;
    rd_ready_o = 1'b0;
    unique case (st_q)
      RD_IDLE: begin
        rd_ready_o = imm_ready;
        if (start_stall) begin
          dem_o = ~smp_i;
          st_d  = (STALL_CYC == 1) ? RD_DATA : RD_STALL;
        end
      end
      RD_STALL: begin
        dem_o = snap_q;
        if (cnt_q == CW'(STALL_CYC - 1)) st_d = RD_DATA;
      end
      RD_DATA: begin
        rd_ready_o = rd_req_i;
        if (rd_req_i) st_d = RD_IDLE;
      end
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      snap_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q <= st_d;
      if (start_stall) begin
        snap_q <= ~smp_i;
        cnt_q  <= CW'(1);
      end else if (st_q == RD_STALL) begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R10: the requester holds the request through the stall
  p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RD_STALL) |-> rd_req_i);

  // R2: the data phase lasts one cycle and follows a stall
  p_data_after_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RD_DATA) |-> ($past(st_q) != RD_DATA));

  // R9: the captured mode does not change during a stall
  p_snap_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RD_STALL && $past(st_q) == RD_STALL) |-> $stable(snap_q));

  // R10: ready only with a request
  p_ready_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready_o |-> rd_req_i);
endmodule

// File: rtl/insamp_top.sv
module insamp_top
  import insamp_pkg::*;
#(
  parameter int unsigned N_BANKS   = DEF_BANKS,
  parameter int unsigned BANK_W    = DEF_BANK_W,
  parameter int unsigned STALL_CYC = DEF_STALL
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_BANKS*BANK_W-1:0] pad_i,
  input  logic [N_BANKS*BANK_W-1:0] in_en_i,
  input  logic [N_BANKS-1:0]        smp_always_i,
  input  logic                      rd_req_i,
  output logic                      rd_ready_o,
  output logic [N_BANKS*BANK_W-1:0] rd_data_o
);
  localparam int unsigned NPIN = N_BANKS * BANK_W;

  logic [N_BANKS-1:0] dem;
  logic [N_BANKS-1:0] bank_run;
  logic [NPIN-1:0]    sync_q;

  function automatic logic [NPIN-1:0] gate_pins(input logic [NPIN-1:0] v,
                                                input logic [NPIN-1:0] en);
    return v & en;
  endfunction

  insamp_rdctl #(.NB(N_BANKS), .STALL_CYC(STALL_CYC)) u_rdctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_i     (smp_always_i),
    .rd_req_i  (rd_req_i),
    .rd_ready_o(rd_ready_o),
    .dem_o     (dem)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign bank_run[b] = smp_always_i[b] | dem[b];
    insamp_bank #(.W(BANK_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (bank_run[b]),
      .pin_en_i(in_en_i[b*BANK_W +: BANK_W]),
      .d_i     (pad_i[b*BANK_W +: BANK_W]),
      .q_o     (sync_q[b*BANK_W +: BANK_W])
    );
  end

  assign rd_data_o = gate_pins(sync_q, in_en_i);

  // R3: every bank continuous, an idle request is answered at once
  p_imm_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && (&smp_always_i) && !$past(rd_req_i)) |-> rd_ready_o);
endmodule

// File: tb/insamp_top_tb.sv
module insamp_top_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [3:0]  smp;
    logic [31:0] en;
    logic [31:0] pad;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{4'h0, 32'hFFFF_FFFF, 32'hA5A5_3C3C},
    '{4'hF, 32'hFFFF_FFFF, 32'h1234_5678},
    '{4'h5, 32'hFFFF_FFFF, 32'hDEAD_BEEF},
    '{4'hF, 32'h00FF_FF00, 32'hFFFF_FFFF},
    '{4'h8, 32'hF0F0_F0F0, 32'h0F0F_FFFF},
    '{4'h0, 32'h0000_0001, 32'h0000_0003}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pad = '0;
  logic [31:0] en = '0;
  logic [3:0]  smp = '0;
  logic        req = 1'b0;
  logic        rdy;
  logic [31:0] data;
  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insamp_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pad_i       (pad),
    .in_en_i     (en),
    .smp_always_i(smp),
    .rd_req_i    (req),
    .rd_ready_o  (rdy),
    .rd_data_o   (data)
  );

  function automatic int exp_stall(input logic [3:0] s);
    return (s == 4'hF) ? 0 : 2;
  endfunction

  task automatic chk(input bit ok, input string tg,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  // called right after a falling edge; leaves the bench at a falling edge
  task automatic do_read(input int est, input logic [31:0] ed, input string tg);
    int n = 0;
    req = 1'b1;
    #1;
    while (!rdy && n < 10) begin
      @(negedge clk); #1; n++;
    end
    chk(n == est, {tg, " stall"}, 32'(n), 32'(est));
    chk(data == ed, {tg, " data"}, data, ed);
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    smp = 4'hF; en = '1; pad = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rdy == 1'b0, "R1 idle ready", 32'(rdy), 0);
    @(negedge clk);
    // R1: no edge since the synchronizers were cleared? one edge passed: only stage 1 loaded
    do_read(0, 32'h0, "R1");

    // table walk: R2, R3, R4, R5, R6
    for (int i = 0; i < NVEC; i++) begin
      smp = VECS[i].smp; en = VECS[i].en; pad = VECS[i].pad;
      repeat (3) @(negedge clk);
      do_read(exp_stall(VECS[i].smp), VECS[i].pad & VECS[i].en,
              (VECS[i].smp == 4'h0) ? "R2" : (VECS[i].smp == 4'hF) ? "R3" : "R4");
    end

    // R6 and R7: disabled pins read 0 and hold their flops
    smp = 4'hF; en = '1; pad = 32'h1122_3344;
    repeat (3) @(negedge clk);
    en = 32'hFFFF_FF00; pad = 32'h5566_7788;
    repeat (4) @(negedge clk);
    do_read(0, 32'h5566_7700, "R6");
    en = '1;
    do_read(0, 32'h5566_7744, "R7");
    repeat (3) @(negedge clk);
    do_read(0, 32'h5566_7788, "R7 refresh");

    // R8: on-demand banks stay frozen between reads
    smp = 4'h0; pad = 32'hCAFE_0001;
    repeat (3) @(negedge clk);
    do_read(2, 32'hCAFE_0001, "R8 first");
    pad = 32'h0BAD_F00D;
    repeat (5) @(negedge clk);
    smp = 4'hF;
    do_read(0, 32'hCAFE_0001, "R8 stale");
    repeat (3) @(negedge clk);
    do_read(0, 32'h0BAD_F00D, "R8 fresh");

    // R9: mode change mid-stall does not shorten it
    smp = 4'h0; pad = 32'h7E57_0099;
    repeat (2) @(negedge clk);
    req = 1'b1; #1;
    chk(rdy == 1'b0, "R9 cycle0", 32'(rdy), 0);
    @(negedge clk); smp = 4'hF; #1;
    chk(rdy == 1'b0, "R9 cycle1", 32'(rdy), 0);
    @(negedge clk); #1;
    chk(rdy == 1'b1, "R9 cycle2", 32'(rdy), 1);
    chk(data == 32'h7E57_0099, "R9 data", data, 32'h7E57_0099);
    @(negedge clk); req = 1'b0;

    // R10: held request starts a new read after completion
    smp = 4'h0;
    repeat (2) @(negedge clk);
    req = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk(rdy == 1'b1, "R10 first ready", 32'(rdy), 1);
    @(negedge clk); #1;
    chk(rdy == 1'b0, "R10 second stall", 32'(rdy), 0);
    @(negedge clk); #1;
    chk(rdy == 1'b0, "R10 second stall b", 32'(rdy), 0);
    @(negedge clk); #1;
    chk(rdy == 1'b1, "R10 second ready", 32'(rdy), 1);
    @(negedge clk); req = 1'b0; #1;
    chk(rdy == 1'b0, "R10 no request", 32'(rdy), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule